// File: doc/BRIEF.md
# Stepper Burst Controller with Limit Switch Status

This block drives a stepper motor driver with a finite burst of step pulses. A one-cycle start strobe carries the number of steps and the direction. The block then emits that many pulses, each held for a programmed number of time units, with a programmed pause between pulses. Time is counted in units of an external tick enable that pulses once every 10 µs. A busy flag stays high for the whole burst. An abort strobe ends the burst early. The block needs no enable and reacts to no trigger other than its own start strobe.

Two output encodings are offered. In normal encoding, one line gives the direction and the other carries the steps. In enhanced encoding, a clockwise step is a pulse on the pulse line with the direction line low, and a counterclockwise step is a pulse on the direction line with the pulse line low.

Two limit switch inputs (clockwise and counterclockwise) are resynchronised and adjusted for the selected polarity. Each is reported as a live level and as a sticky "seen" flag. The sticky flag survives after the motor backs off the limit and is cleared by a status-read strobe.

The sequencer is a three-state machine:
- IDLE: waits for a start strobe carrying a non-zero step count, then moves to MARK.
- MARK: the step line is high. After the programmed width it goes back to IDLE if this was the last step, and otherwise moves to SPACE.
- SPACE: the pause between pulses. After the programmed gap it returns to MARK.
- From MARK or SPACE, a pending abort moves the machine to IDLE on the next tick.

Top module: `stepper_burst_ctrl`

## Requirements
- R1: With `enh_mode`=0 captured at start, `dir_out` is high for the whole burst when `start_ccw`=1 and low when `start_ccw`=0. `pulse_out` rises exactly once per step.
- R2: With `enh_mode`=1 captured at start, a clockwise burst (`start_ccw`=0) pulses `pulse_out` once per step while `dir_out` stays low. A counterclockwise burst pulses `dir_out` once per step while `pulse_out` stays low.
- R3: Every step pulse stays high for exactly W ticks, and the pause between consecutive pulses lasts exactly G ticks, where W=`width_ticks` and G=`gap_ticks` are captured at start. There is no pause after the last pulse. A value of 0 behaves as 1.
- R4: A start seen in IDLE with a non-zero `start_steps` raises `busy` in the next cycle. The step count, direction, mode, W and G are captured in that same cycle. `busy` falls in the cycle after the last pulse ends. When the start coincides with a tick, busy lasts steps·W·T + (steps−1)·G·T cycles, where T is the tick period in clock cycles.
- R5: A start with `start_steps`=0 produces no pulse and leaves `busy` low.
- R6: A start received while `busy` is high is ignored. The running burst keeps its count, direction and timing.
- R7: An abort while busy returns the block to IDLE at the first tick seen in or after the abort cycle. At that point `busy`, `pulse_out` and `dir_out` are all low. A start in the same cycle as an abort is ignored.
- R8: Whenever `busy` is low, both `pulse_out` and `dir_out` are low. After reset, `busy`, both output lines and both sticky flags are low.
- R9: `es_level[i]` = `es_enable` AND (`es_in[i]` XOR `es_active_low`), seen through a two-stage synchronizer. Bit 0 is the clockwise limit and bit 1 the counterclockwise limit. Both bits read 0 while `es_enable` is low.
- R10: `es_seen[i]` is set in the cycle after `es_level[i]` is high. It stays set after the level drops, and `stat_rd` clears it. When a set and a clear fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle time unit enable (every 10 µs) |
| enh_mode | input | 1 | 0 = normal encoding, 1 = enhanced encoding |
| width_ticks | input | TIME_W | Pulse width in ticks |
| gap_ticks | input | TIME_W | Pause between pulses in ticks |
| start | input | 1 | Start strobe |
| start_steps | input | CNT_W | Step count carried by the start strobe |
| start_ccw | input | 1 | Direction carried by the start strobe (1 = counterclockwise) |
| abort | input | 1 | Abort strobe |
| es_in | input | 2 | Raw limit switch inputs, bit 0 clockwise, bit 1 counterclockwise |
| es_active_low | input | 1 | Limit switch polarity select |
| es_enable | input | 1 | Limit switch reporting enable |
| stat_rd | input | 1 | Status-read strobe that clears the sticky flags |
| pulse_out | output | 1 | Pulse line to the motor driver |
| dir_out | output | 1 | Direction line to the motor driver |
| busy | output | 1 | High while a burst runs |
| es_level | output | 2 | Live limit switch levels |
| es_seen | output | 2 | Sticky limit switch flags |

## Verification
The assertions assume the following about the inputs:
- `tick`, `start`, `abort` and `stat_rd` are single-cycle strobes.
- The timing and mode inputs are steady whenever a start is issued.
- `es_in` may change at any time, since it is resynchronised.

The stimulus changes every input half a clock cycle away from the active edge. It drives `tick` high for one cycle in every four. Each burst start is issued in a tick cycle, so that the expected pulse, pause and busy lengths are exact multiples of the tick period. Aborts are placed in non-tick cycles, so that the wait for the next tick is visible at the ports.

// File: rtl/stp_pkg.sv
package stp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MARK  = 2'd1,
        ST_SPACE = 2'd2
    } seq_state_t;

    localparam int ES_CHANNELS = 2;
    localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/stp_sync.sv
module stp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[STAGES-2:0], d};
    end

    assign q = shreg[STAGES-1];
endmodule

// File: rtl/stp_endstop.sv
module stp_endstop #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    input  logic active_low,
    input  logic enable,
    input  logic stat_rd,
    output logic level,
    output logic seen
);
    logic synced;
    logic seen_q;

    stp_sync #(.STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (synced)
    );

    always_comb begin
        level = enable & (synced ^ active_low);
    end

    // Sticky flag: a new detection wins over a read in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       seen_q <= 1'b0;
        else if (level)   seen_q <= 1'b1;
        else if (stat_rd) seen_q <= 1'b0;
    end

    assign seen = seen_q;

    AST_SEEN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        level |=> seen_q);                                              // R10
    AST_SEEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !stat_rd) |=> seen_q);                               // R10
    AST_SEEN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !level) |=> !seen_q);                               // R10
endmodule

// File: rtl/stp_sequencer.sv
module stp_sequencer
    import stp_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int TIME_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic [CNT_W-1:0]  start_steps,
    input  logic              start_ccw,
    input  logic              start_enh,
    input  logic              abort,
    input  logic [TIME_W-1:0] width_ticks,
    input  logic [TIME_W-1:0] gap_ticks,
    output logic              busy,
    output logic              mark,
    output logic              cmd_ccw,
    output logic              cmd_enh
);
    localparam logic [CNT_W-1:0]  LAST_STEP = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [TIME_W-1:0] MIN_UNITS = {{(TIME_W-1){1'b0}}, 1'b1};

    seq_state_t        state_q, state_d;
    logic [CNT_W-1:0]  remain_q;
    logic [TIME_W-1:0] timer_q;
    logic [TIME_W-1:0] wid_q, gap_q;
    logic              ccw_q, enh_q, abort_pend_q;

    logic              cmd_accept;
    logic              stop_now;
    logic              phase_done;
    logic [TIME_W-1:0] phase_lim;

    always_comb begin
        cmd_accept = (state_q == ST_IDLE) && start && !abort && (start_steps != '0);
        stop_now   = (state_q != ST_IDLE) && tick && (abort || abort_pend_q);
        if (state_q == ST_SPACE) phase_lim = (gap_q == '0) ? MIN_UNITS : gap_q;
        else                     phase_lim = (wid_q == '0) ? MIN_UNITS : wid_q;
        phase_done = tick && (timer_q >= phase_lim - MIN_UNITS);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_accept) state_d = ST_MARK;
            end
            ST_MARK: begin
                if (stop_now)        state_d = ST_IDLE;
                else if (phase_done) state_d = (remain_q == LAST_STEP) ? ST_IDLE : ST_SPACE;
            end
            ST_SPACE: begin
                if (stop_now)        state_d = ST_IDLE;
                else if (phase_done) state_d = ST_MARK;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Burst datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
            timer_q  <= '0;
            wid_q    <= '0;
            gap_q    <= '0;
            ccw_q    <= 1'b0;
            enh_q    <= 1'b0;
        end else if (cmd_accept) begin
            remain_q <= start_steps;
            timer_q  <= '0;
            wid_q    <= width_ticks;
            gap_q    <= gap_ticks;
            ccw_q    <= start_ccw;
            enh_q    <= start_enh;
        end else if (state_q != ST_IDLE) begin
            if (stop_now || phase_done) timer_q <= '0;
            else if (tick)              timer_q <= timer_q + MIN_UNITS;
            if (stop_now)               remain_q <= '0;
            else if (state_q == ST_MARK && phase_done) remain_q <= remain_q - LAST_STEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               abort_pend_q <= 1'b0;
        else if (state_q == ST_IDLE || stop_now)  abort_pend_q <= 1'b0;
        else if (abort)                           abort_pend_q <= 1'b1;
    end

    // Outputs
    always_comb begin
        busy    = (state_q != ST_IDLE);
        mark    = (state_q == ST_MARK);
        cmd_ccw = ccw_q;
        cmd_enh = enh_q;
    end

    AST_ZERO_STEPS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && start_steps == '0) |=> (state_q == ST_IDLE)); // R5
    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));                                  // R4
    AST_BUSY_HAS_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (remain_q != '0));                                     // R4
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !tick) |=> ($stable(remain_q) && $stable(timer_q)
                                      && $stable(ccw_q) && $stable(enh_q))); // R6
endmodule

// File: rtl/stp_line_encode.sv
module stp_line_encode (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic mark,
    input  logic enh,
    input  logic ccw,
    output logic pulse_out,
    output logic dir_out
);
    always_comb begin
        pulse_out = 1'b0;
        dir_out   = 1'b0;
        if (busy) begin
            if (!enh) begin
                pulse_out = mark;
                dir_out   = ccw;
            end else if (!ccw) begin
                pulse_out = mark;
            end else begin
                dir_out   = mark;
            end
        end
    end

    AST_ENH_CCW_PULSE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && enh && ccw) |-> !pulse_out);                           // R2
    AST_ENH_CW_DIR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && enh && !ccw) |-> !dir_out);                            // R2
    AST_NORMAL_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !enh) |-> (dir_out == ccw));                           // R1
endmodule

// File: rtl/stepper_burst_ctrl.sv
module stepper_burst_ctrl
    import stp_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int TIME_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              enh_mode,
    input  logic [TIME_W-1:0] width_ticks,
    input  logic [TIME_W-1:0] gap_ticks,
    input  logic              start,
    input  logic [CNT_W-1:0]  start_steps,
    input  logic              start_ccw,
    input  logic              abort,
    input  logic [1:0]        es_in,
    input  logic              es_active_low,
    input  logic              es_enable,
    input  logic              stat_rd,
    output logic              pulse_out,
    output logic              dir_out,
    output logic              busy,
    output logic [1:0]        es_level,
    output logic [1:0]        es_seen
);
    logic seq_mark, seq_ccw, seq_enh;

    stp_sequencer #(.CNT_W(CNT_W), .TIME_W(TIME_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .start       (start),
        .start_steps (start_steps),
        .start_ccw   (start_ccw),
        .start_enh   (enh_mode),
        .abort       (abort),
        .width_ticks (width_ticks),
        .gap_ticks   (gap_ticks),
        .busy        (busy),
        .mark        (seq_mark),
        .cmd_ccw     (seq_ccw),
        .cmd_enh     (seq_enh)
    );

    stp_line_encode u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .mark      (seq_mark),
        .enh       (seq_enh),
        .ccw       (seq_ccw),
        .pulse_out (pulse_out),
        .dir_out   (dir_out)
    );

    for (genvar gi = 0; gi < ES_CHANNELS; gi++) begin : g_limit
        stp_endstop #(.STAGES(SYNC_STAGES)) u_es (
            .clk        (clk),
            .rst_n      (rst_n),
            .raw_in     (es_in[gi]),
            .active_low (es_active_low),
            .enable     (es_enable),
            .stat_rd    (stat_rd),
            .level      (es_level[gi]),
            .seen       (es_seen[gi])
        );
    end

    AST_IDLE_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!pulse_out && !dir_out));                            // R8
    AST_ABORT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort && tick) |=> (!busy && !pulse_out && !dir_out)); // R7
    AST_START_WITH_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && abort) |=> !busy);                           // R7
endmodule

// File: tb/sim_stepper_burst_ctrl.sv
module sim_stepper_burst_ctrl;
    localparam int P = 4;

    typedef struct packed {
        logic       enh;
        logic       ccw;
        logic [7:0] steps;
        logic [7:0] wid;
        logic [7:0] gap;
    } vec_t;

    localparam vec_t VTAB [6] = '{
        '{1'b0, 1'b0, 8'd3, 8'd2, 8'd3},
        '{1'b0, 1'b1, 8'd2, 8'd1, 8'd1},
        '{1'b1, 1'b0, 8'd4, 8'd3, 8'd2},
        '{1'b1, 1'b1, 8'd3, 8'd2, 8'd1},
        '{1'b0, 1'b0, 8'd2, 8'd0, 8'd0},
        '{1'b1, 1'b1, 8'd1, 8'd4, 8'd2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, enh_mode = 1'b0, start = 1'b0, start_ccw = 1'b0, abort = 1'b0;
    logic [7:0]  width_ticks = 8'd1, gap_ticks = 8'd1;
    logic [15:0] start_steps = 16'd0;
    logic [1:0]  es_in = 2'b00;
    logic es_active_low = 1'b0, es_enable = 1'b0, stat_rd = 1'b0;
    logic pulse_out, dir_out, busy;
    logic [1:0] es_level, es_seen;

    int total = 0, bad = 0, cnt = 0;
    int rises_p, rises_d, hi_run, lo_run, last_hi, last_lo, busy_cnt, level_bad;
    logic prev_line, mon_sel, exp_enh, exp_ccw;

    always #10 clk = ~clk;

    stepper_burst_ctrl #(.CNT_W(16), .TIME_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .enh_mode(enh_mode),
        .width_ticks(width_ticks), .gap_ticks(gap_ticks), .start(start),
        .start_steps(start_steps), .start_ccw(start_ccw), .abort(abort),
        .es_in(es_in), .es_active_low(es_active_low), .es_enable(es_enable),
        .stat_rd(stat_rd), .pulse_out(pulse_out), .dir_out(dir_out),
        .busy(busy), .es_level(es_level), .es_seen(es_seen)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic mon_reset(input logic sel, input logic e, input logic c);
        rises_p = 0; rises_d = 0; hi_run = 0; lo_run = 0;
        last_hi = 0; last_lo = 0; busy_cnt = 0; level_bad = 0;
        prev_line = 1'b0; mon_sel = sel; exp_enh = e; exp_ccw = c;
    endtask

    // One clock cycle: sample outputs at the falling edge, then drive inputs.
    task automatic cyc(input logic s, input logic a, input logic r);
        logic line;
        @(negedge clk);
        line = mon_sel ? dir_out : pulse_out;
        if (pulse_out && !(mon_sel ? 1'b0 : prev_line) && !mon_sel) rises_p++;
        if (line && !prev_line) begin
            if (mon_sel) rises_d++;
            if ((mon_sel ? rises_d : rises_p) > 1) last_lo = lo_run;
            lo_run = 0;
        end
        if (line) hi_run++;
        else begin
            if (prev_line) last_hi = hi_run;
            hi_run = 0;
            lo_run++;
        end
        prev_line = line;
        if (busy) begin
            busy_cnt++;
            if (!exp_enh && dir_out != exp_ccw) level_bad++;
            if (exp_enh && !exp_ccw && dir_out) level_bad++;
            if (exp_enh && exp_ccw && pulse_out) level_bad++;
        end
        tick = (cnt % P == 0);
        cnt++;
        start = s; abort = a; stat_rd = r;
    endtask

    task automatic align_start();
        while (cnt % P != 0) cyc(1'b0, 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 1'b0);
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 2000; k++) begin
            cyc(1'b0, 1'b0, 1'b0);
            if (!busy) break;
        end
        cyc(1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        mon_reset(1'b0, 1'b0, 1'b0);
        repeat (3) cyc(1'b0, 1'b0, 1'b0);
        chk("R8 reset busy", busy, 0);
        chk("R8 reset lines", {pulse_out, dir_out}, 0);
        chk("R8 reset seen", es_seen, 0);
        rst_n = 1'b1;
        repeat (2) cyc(1'b0, 1'b0, 1'b0);

        // Vector table walk: R1, R2, R3, R4
        for (int v = 0; v < 6; v++) begin
            vec_t t;
            int w, g, n, ep, ed;
            t = VTAB[v];
            w = (t.wid == 0) ? 1 : int'(t.wid);
            g = (t.gap == 0) ? 1 : int'(t.gap);
            n = int'(t.steps);
            enh_mode = t.enh; start_ccw = t.ccw; start_steps = {8'h00, t.steps};
            width_ticks = t.wid; gap_ticks = t.gap;
            mon_reset(t.enh & t.ccw, t.enh, t.ccw);
            align_start();
            wait_idle();
            ep = (t.enh && t.ccw) ? 0 : n;
            ed = n;
            if (t.enh && t.ccw) chk("R2 dir-line steps", rises_d, ed);
            else if (t.enh)     chk("R2 pulse-line steps", rises_p, ep);
            else                chk("R1 pulse-line steps", rises_p, ep);
            chk(t.enh ? "R2 idle line level" : "R1 direction level", level_bad, 0);
            chk("R3 pulse width cycles", last_hi, w * P);
            if (n > 1) chk("R3 gap cycles", last_lo, g * P);
            chk("R4 busy length", busy_cnt, n * w * P + (n - 1) * g * P);
            chk("R8 lines low after burst", {pulse_out, dir_out}, 0);
        end

        // R5: zero step count
        mon_reset(1'b0, 1'b0, 1'b0);
        start_steps = 16'd0; enh_mode = 1'b0; start_ccw = 1'b1;
        cyc(1'b1, 1'b0, 1'b0);
        repeat (4) cyc(1'b0, 1'b0, 1'b0);
        chk("R5 zero steps busy", busy_cnt, 0);
        chk("R5 zero steps lines", {pulse_out, dir_out}, 0);

        // R6: start while busy is ignored
        start_steps = 16'd5; start_ccw = 1'b0; width_ticks = 8'd1; gap_ticks = 8'd1;
        mon_reset(1'b0, 1'b0, 1'b0);
        align_start();
        repeat (8) cyc(1'b0, 1'b0, 1'b0);
        start_steps = 16'd2; start_ccw = 1'b1;
        cyc(1'b1, 1'b0, 1'b0);
        wait_idle();
        chk("R6 step count kept", rises_p, 5);
        chk("R6 direction kept", level_bad, 0);
        chk("R6 busy length kept", busy_cnt, 5 * P + 4 * P);

        // R7: abort waits for the next tick, then idles
        start_steps = 16'd6; start_ccw = 1'b1; width_ticks = 8'd2; gap_ticks = 8'd2;
        mon_reset(1'b0, 1'b0, 1'b1);
        align_start();
        repeat (8) cyc(1'b0, 1'b0, 1'b0);
        while (cnt % P != 2) cyc(1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R7 abort waits for tick", busy, 1);
        cyc(1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R7 abort busy low", busy, 0);
        chk("R7 abort lines low", {pulse_out, dir_out}, 0);
        chk("R7 abort cut burst", (rises_p > 0 && rises_p < 6) ? 1 : 0, 1);
        mon_reset(1'b0, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 1'b0);
        repeat (3) cyc(1'b0, 1'b0, 1'b0);
        chk("R7 start with abort ignored", busy_cnt, 0);

        // R9, R10: limit switches, active-high
        es_enable = 1'b1; es_active_low = 1'b0; es_in = 2'b01;
        repeat (4) cyc(1'b0, 1'b0, 1'b0);
        chk("R9 cw level", es_level, 2'b01);
        chk("R10 cw seen", es_seen, 2'b01);
        es_in = 2'b00;
        repeat (4) cyc(1'b0, 1'b0, 1'b0);
        chk("R9 level released", es_level, 2'b00);
        chk("R10 seen sticky", es_seen, 2'b01);
        cyc(1'b0, 1'b0, 1'b1);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R10 read clears", es_seen, 2'b00);
        es_in = 2'b10;
        repeat (4) cyc(1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b1);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R10 set wins over read", es_seen, 2'b10);
        es_in = 2'b00;
        repeat (4) cyc(1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b1);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R10 cleared after release", es_seen, 2'b00);

        // R9: active-low polarity
        es_active_low = 1'b1; es_in = 2'b01;
        repeat (4) cyc(1'b0, 1'b0, 1'b0);
        chk("R9 active-low level", es_level, 2'b10);

        // R9, R10: reporting disabled
        es_enable = 1'b0; es_in = 2'b00;
        repeat (4) cyc(1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b1);
        repeat (3) cyc(1'b0, 1'b0, 1'b0);
        chk("R9 disabled level", es_level, 2'b00);
        chk("R10 disabled no set", es_seen, 2'b00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R4 act=%0d exp=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule